// File: doc/BRIEF.md
# Programmable Multi-Output Clock Prescaler Bank

This block derives four timing outputs from one main clock: a fast system tick, a slow square-wave clock and two auxiliary ticks. Each output comes from its own programmable counter. The fast tick and the auxiliary ticks are one-cycle enable pulses. The slow output is a 50% duty square wave. Three byte-wide configuration registers hold the divisors and sit behind a simple synchronous write port with a combinational read path.

The fast register also holds a 3-bit multiplier-mode field for an external frequency synthesizer. The block only stores this field and reports whether its value is a supported encoding. Each auxiliary counter runs only while its own enable input is high and the main clock is reported stable. Otherwise the counter is held cleared and its output stays low.

A divisor change never cuts a period short. Each counter keeps the limit it latched and picks up the new value only at its next terminal count.

Top module: `clkPrescalerBank`

## Requirements
- R1: After reset, the registers read 0x4F at address 0 (fast), 0xB6 at address 1 (slow) and 0xFF at address 2 (auxiliary). `slowClk` is low and `modeValid` is high.
- R2: `fastTick` pulses high for one cycle every F+1 main-clock cycles, where F is bits 3:0 of the fast register.
- R3: `slowClk` toggles every S+1 cycles, where S is the 8-bit slow register, so its period is 2×(S+1) cycles.
- R4: `aux1Tick` pulses every A1+1 cycles, where A1 is bits 3:0 of the auxiliary register. `aux2Tick` pulses every A2+1 cycles, where A2 is bits 7:4.
- R5: While its enable input (`auxEn1` or `auxEn2`) is low, or while `srcStable` is low, an auxiliary output stays low and its counter is cleared. With divisor A, the first pulse after the run condition returns appears A cycles after the first sampling edge at which the condition holds.
- R6: A written divisor takes effect at the counter's next terminal count. The period in progress completes with the old value.
- R7: `modeValid` is high exactly when bits 6:4 of the fast register hold 011, 100 or 101. Any other value is still stored and read back unchanged.
- R8: Bit 7 of the fast register always reads 0. Address 3 reads 0x00, and writes to address 3 change no register.
- R9: A write takes effect at the rising edge where `regWrEn` is high. `regRdData` shows the register selected by `regAddr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 fast, 1 slow, 2 auxiliary) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| srcStable | input | 1 | Main clock reported stable |
| auxEn1 | input | 1 | Run enable for auxiliary output 1 |
| auxEn2 | input | 1 | Run enable for auxiliary output 2 |
| fastTick | output | 1 | Fast system clock enable pulse |
| slowClk | output | 1 | Slow square-wave clock |
| aux1Tick | output | 1 | Auxiliary 1 enable pulse |
| aux2Tick | output | 1 | Auxiliary 2 enable pulse |
| modeValid | output | 1 | Multiplier-mode field holds a supported code |

## Verification
Register contents and `modeValid` change one edge after a write and appear at the next falling edge, so the bench reads them there. Read data is combinational, so each read is sampled a short delay after the address is driven. Period checks count falling edges between successive pulses or toggles, and only after at least one terminal count has passed since the write. The bench waits for that count because a new divisor becomes active only at a terminal count. The mid-period test counts from the last old pulse through the write, and expects the full old period followed by the new one. The restart check counts edges from the falling edge where the run condition returns.

// File: rtl/clkPrescalerPkg.sv
package clkPrescalerPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 4;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_FAST = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SLOW = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_AUX  = 2'd2;

  localparam logic [DATA_W-1:0] RST_FAST = 8'h4F;
  localparam logic [DATA_W-1:0] RST_SLOW = 8'hB6;
  localparam logic [DATA_W-1:0] RST_AUX  = 8'hFF;

  typedef struct packed {
    logic wrFast;
    logic wrSlow;
    logic wrAux;
  } ctrlStrobes_t;

  function automatic logic modeSupported(input logic [MODE_W-1:0] m);
    return (m == 3'b011) || (m == 3'b100) || (m == 3'b101);
  endfunction
endpackage

// File: rtl/clkDivCounter.sv
module clkDivCounter #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_LIM = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         term
);
  logic [W-1:0] cnt;
  logic [W-1:0] curLim;

  assign term = run && (cnt == curLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      curLim <= RST_LIM;
    end else if (!run || term) begin
      cnt    <= '0;
      curLim <= limit;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkPrescalerCtrl.sv
module clkPrescalerCtrl
  import clkPrescalerPkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes.wrFast = regWrEn && (regAddr == ADDR_FAST);
    strobes.wrSlow = regWrEn && (regAddr == ADDR_SLOW);
    strobes.wrAux  = regWrEn && (regAddr == ADDR_AUX);
  end
endmodule

// File: rtl/clkPrescalerDatapath.sv
module clkPrescalerDatapath
  import clkPrescalerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              srcStable,
  input  logic [1:0]        auxEn,
  output logic              fastTick,
  output logic              slowClk,
  output logic [1:0]        auxTick,
  output logic              modeValid
);
  localparam int FAST_STORE_W = DATA_W - 1;

  logic [FAST_STORE_W-1:0] fastReg;
  logic [DATA_W-1:0]       slowReg;
  logic [DATA_W-1:0]       auxReg;
  logic                    slowTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastReg <= RST_FAST[FAST_STORE_W-1:0];
      slowReg <= RST_SLOW;
      auxReg  <= RST_AUX;
    end else begin
      if (strobes.wrFast) fastReg <= regWrData[FAST_STORE_W-1:0];
      if (strobes.wrSlow) slowReg <= regWrData;
      if (strobes.wrAux)  auxReg  <= regWrData;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_FAST: regRdData = {1'b0, fastReg};
      ADDR_SLOW: regRdData = slowReg;
      ADDR_AUX:  regRdData = auxReg;
      default:   regRdData = '0;
    endcase
  end

  assign modeValid = modeSupported(fastReg[DIV_W +: MODE_W]);

  clkDivCounter #(.W(DIV_W), .RST_LIM(RST_FAST[DIV_W-1:0])) fastCnt (
    .clk(clk), .rstN(rstN), .run(1'b1),
    .limit(fastReg[DIV_W-1:0]), .term(fastTick)
  );

  clkDivCounter #(.W(DATA_W), .RST_LIM(RST_SLOW)) slowCnt (
    .clk(clk), .rstN(rstN), .run(1'b1),
    .limit(slowReg), .term(slowTerm)
  );

  always_ff @(posedge clk) begin
    if (!rstN)         slowClk <= 1'b0;
    else if (slowTerm) slowClk <= ~slowClk;
  end

  for (genvar g = 0; g < 2; g++) begin : gAux
    clkDivCounter #(.W(DIV_W), .RST_LIM(RST_AUX[g*DIV_W +: DIV_W])) auxCnt (
      .clk(clk), .rstN(rstN), .run(auxEn[g] && srcStable),
      .limit(auxReg[g*DIV_W +: DIV_W]), .term(auxTick[g])
    );
  end
endmodule

// File: rtl/clkPrescalerBank.sv
module clkPrescalerBank
  import clkPrescalerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              srcStable,
  input  logic              auxEn1,
  input  logic              auxEn2,
  output logic              fastTick,
  output logic              slowClk,
  output logic              aux1Tick,
  output logic              aux2Tick,
  output logic              modeValid
);
  ctrlStrobes_t strobes;
  logic [1:0]   auxTick;

  clkPrescalerCtrl ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobes(strobes)
  );

  clkPrescalerDatapath dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcStable(srcStable),
    .auxEn({auxEn2, auxEn1}), .fastTick(fastTick), .slowClk(slowClk),
    .auxTick(auxTick), .modeValid(modeValid)
  );

  assign aux1Tick = auxTick[0];
  assign aux2Tick = auxTick[1];
endmodule

// File: rtl/clkPrescalerBankChecker.sv
module clkPrescalerBankChecker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       srcStable,
  input logic       auxEn1,
  input logic       auxEn2,
  input logic       fastTick,
  input logic       slowClk,
  input logic       aux1Tick,
  input logic       aux2Tick,
  input logic       modeValid
);
  a_r5_aux1_gated: assert property (@(posedge clk) disable iff (!rstN)
    !(auxEn1 && srcStable) |-> !aux1Tick);

  a_r5_aux2_gated: assert property (@(posedge clk) disable iff (!rstN)
    !(auxEn2 && srcStable) |-> !aux2Tick);

  a_r7_mode_decode: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (modeValid == (regRdData[6:4] inside {3'b011, 3'b100, 3'b101})));

  a_r8_bit7_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> !regRdData[7]);

  a_r8_addr3_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData == 8'h00));

  a_r9_aux_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=> (regAddr != 2'd2 || regRdData == $past(regWrData)));
endmodule

bind clkPrescalerBank clkPrescalerBankChecker chk (.*);

// File: tb/clkPrescalerBank_test.sv
`timescale 1ns/1ps
module clkPrescalerBank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       srcStable = 1'b1;
  logic       auxEn1 = 1'b1;
  logic       auxEn2 = 1'b1;
  logic       fastTick, slowClk, aux1Tick, aux2Tick, modeValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkPrescalerBank uut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return fastTick;
      1: return aux1Tick;
      2: return aux2Tick;
      default: return slowClk;
    endcase
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Cycles between successive pulses (sel 0..2) or toggles (sel 3).
  task automatic measure(input int sel, output int gap);
    logic prev;
    int n;
    gap = -1;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      prev = pick(sel);
      do begin
        @(negedge clk);
        n++;
      end while (n < 3000 && ((sel == 3) ? (pick(sel) == prev) : !pick(sel)));
      gap = (n >= 3000) ? -1 : n;
    end
  endtask

  task automatic testReset();
    logic [7:0] d;
    readReg(2'd0, d); check("R1 fast reset", d, 8'h4F);
    readReg(2'd1, d); check("R1 slow reset", d, 8'hB6);
    readReg(2'd2, d); check("R1 aux reset", d, 8'hFF);
    check("R1 slowClk low", slowClk, 0);
    check("R1 modeValid", modeValid, 1);
  endtask

  task automatic testDefaultPeriods();
    int g;
    measure(0, g); check("R2 default fast period", g, 16);
    measure(3, g); check("R3 default slow half period", g, 183);
    measure(1, g); check("R4 default aux1 period", g, 16);
  endtask

  task automatic testFast();
    int g;
    writeReg(2'd0, 8'h42); measure(0, g); check("R2 fast div 2", g, 3);
    writeReg(2'd0, 8'h40); measure(0, g); check("R2 fast div 0", g, 1);
    writeReg(2'd0, 8'h47); measure(0, g); check("R2 fast div 7", g, 8);
  endtask

  task automatic testSlow();
    int g;
    writeReg(2'd1, 8'h04); measure(3, g); check("R3 slow div 4", g, 5);
    writeReg(2'd1, 8'h00); measure(3, g); check("R3 slow div 0", g, 1);
  endtask

  task automatic testAux();
    int g;
    writeReg(2'd2, 8'h52); // A2=5 A1=2
    measure(1, g); check("R4 aux1 div 2", g, 3);
    measure(2, g); check("R4 aux2 div 5", g, 6);
  endtask

  task automatic testGating();
    int hits = 0;
    int n = 0;
    @(negedge clk); auxEn1 = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (aux1Tick) hits++;
    end
    check("R5 aux1 held while disabled", hits, 0);
    auxEn1 = 1'b1;
    while (!aux1Tick && n < 100) begin @(negedge clk); n++; end
    check("R5 aux1 restart delay", n, 2);
    hits = 0;
    srcStable = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (aux2Tick || aux1Tick) hits++;
    end
    check("R5 aux held while unstable", hits, 0);
    srcStable = 1'b1;
    n = 0;
    while (!aux2Tick && n < 100) begin @(negedge clk); n++; end
    check("R5 aux2 restart delay", n, 5);
  endtask

  task automatic testMidPeriod();
    int n = 0;
    int g;
    writeReg(2'd0, 8'h49);
    measure(0, g); check("R6 fast div 9 setup", g, 10);
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h42; end
      if (n == 2) regWrEn = 1'b0;
    end while (!fastTick && n < 100);
    check("R6 old period kept", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (!fastTick && n < 100);
    check("R6 new period", n, 3);
  endtask

  task automatic testMode();
    logic [7:0] d;
    writeReg(2'd0, 8'h31); readReg(2'd0, d);
    check("R7 mode 011 valid", modeValid, 1);
    writeReg(2'd0, 8'h70); readReg(2'd0, d);
    check("R7 mode 111 invalid", modeValid, 0);
    check("R7 reserved mode stored", d, 8'h70);
    writeReg(2'd0, 8'h05); check("R7 mode 000 invalid", modeValid, 0);
    writeReg(2'd0, 8'hD3); readReg(2'd0, d);
    check("R8 bit7 reads zero", d, 8'h53);
    check("R7 mode 101 valid", modeValid, 1);
  endtask

  task automatic testAddr3();
    logic [7:0] d;
    writeReg(2'd3, 8'hA5);
    readReg(2'd3, d); check("R8 addr3 reads zero", d, 0);
    readReg(2'd0, d); check("R8 fast unchanged", d, 8'h53);
    readReg(2'd1, d); check("R8 slow unchanged", d, 8'h00);
    readReg(2'd2, d); check("R9 aux holds last write", d, 8'h52);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDefaultPeriods();
    testFast();
    testSlow();
    testAux();
    testGating();
    testMidPeriod();
    testMode();
    testAddr3();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule